// File: doc/BRIEF.md
# PHY Management Interface Master

This block is a register-programmed master for the two-wire PHY management interface (MDC clock, bidirectional MDIO data). Software programs a clock divisor and an enable bit, and loads the write data if the frame is a write. It then writes a command word that carries the PHY address, the register address, a read flag and an initiate bit. The block derives MDC from the host clock. It shifts out a clause-22 style frame, releases MDIO during the turnaround and data phases of a read, and captures the 16 bits returned by the PHY.

The command register carries a ready bit. Software polls it before it launches a frame and again to see that the frame has completed. A read result appears in the read-data register. The register port is a single-cycle write strobe, and read data is combinational on the address.

Top module: `mgmt_phy_master`

## Requirements
- R1: After reset the control word reads 0 (disabled, divisor 0), the command word reads only ready (bit 12) set, write-data and read-data read 0, MDC is low and the MDIO output enable is low.
- R2: During a frame MDC has a period of exactly 2*(1+div) host clock cycles, where div is control bits [7:0]. MDC is low whenever no frame is active.
- R3: While the enable bit (control bit 16) is clear, MDC does not toggle, and a command write with initiate set is ignored, so ready stays 1.
- R4: Each frame sends 32 ones, then 01, then opcode 10 for a read or 01 for a write, then the 5-bit PHY address and the 5-bit register address, each MSB first.
- R5: A write frame drives MDIO for all 64 bit times, with turnaround 10 followed by write-data bits [15:0] MSB first.
- R6: A read frame drives MDIO for the first 46 bit times only. MDIO is sampled on MDC rising edges during the last 16 bit times, and the result appears in read-data bits [15:0] with bits [31:16] reading 0.
- R7: Ready reads 0 from the command write that launches a frame until the frame's last MDC falling edge, then reads 1.
- R8: A command write with initiate set while ready is 0 is ignored, and the frame in progress continues unchanged.
- R9: MDIO output changes only on MDC falling edges, or while MDC is low at frame launch.
- R10: Register offsets are 0x0 control, 0x4 command, 0x8 write data (bits [15:0]) and 0xC read data. The command fields are PHY address [4:0], register address [9:5], read flag bit 10 (1 = read), initiate bit 11 and ready bit 12.
- R11: Clearing enable during a frame abandons it. Ready returns to 1, MDC stays low and MDIO is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A table of frames is run with every divisor from 0 to 4, mixing reads and writes with different PHY and register addresses and data words. Alternating, all-ones and sparse bit patterns show up a shifted, reversed or truncated field. The measured MDC period separates a correct divisor from an off-by-one. Comparing the count of driven bit times tells read framing from write framing. Directed cases cover a launch while disabled, a second initiate while busy and an abort by clearing enable.

// File: rtl/mgmt_phy_master.sv
module mgmt_phy_master #(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_BITS = 64;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int TA_IDX     = 46;
  localparam int DATA_IDX   = 48;
  localparam int EN_BIT     = 16;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

  logic [DIV_W-1:0]      div_q, cnt_q;
  logic                  en_q, busy_q, rd_q, mdc_q;
  logic [15:0]           wdat_q, rdat_q, cap_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [BIT_W-1:0]      bit_q;

  wire sel_ctrl = reg_we && reg_addr == 4'h0;
  wire sel_cmd  = reg_we && reg_addr == 4'h4;
  wire sel_wd   = reg_we && reg_addr == 4'h8;
  wire launch   = sel_cmd && reg_wdata[11] && en_q && !busy_q;
  wire tick     = busy_q && cnt_q == div_q;
  wire new_rd   = reg_wdata[10];
  wire unused_wbits = ^reg_wdata[31:17];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      en_q   <= 1'b0;
      wdat_q <= '0;
      rdat_q <= '0;
      cap_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      mdc_q  <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '1;
    end else begin
      if (sel_ctrl) begin
        div_q <= reg_wdata[DIV_W-1:0];
        en_q  <= reg_wdata[EN_BIT];
      end
      if (sel_wd) wdat_q <= reg_wdata[15:0];

      if (sel_ctrl && !reg_wdata[EN_BIT]) begin
        busy_q <= 1'b0;
        mdc_q  <= 1'b0;
        cnt_q  <= '0;
      end else if (launch) begin
        busy_q <= 1'b1;
        rd_q   <= new_rd;
        mdc_q  <= 1'b0;
        cnt_q  <= '0;
        bit_q  <= '0;
        sh_q   <= {32'hFFFF_FFFF, 2'b01, new_rd ? 2'b10 : 2'b01,
                   reg_wdata[4:0], reg_wdata[9:5],
                   new_rd ? 18'h3_FFFF : {2'b10, wdat_q}};
      end else if (busy_q) begin
        if (tick) begin
          cnt_q <= '0;
          mdc_q <= !mdc_q;
          if (!mdc_q) begin
            if (rd_q && bit_q >= BIT_W'(DATA_IDX)) cap_q <= {cap_q[14:0], mdio_i};
          end else if (bit_q == LAST_BIT) begin
            busy_q <= 1'b0;
            if (rd_q) rdat_q <= cap_q;
          end else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b1};
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = sh_q[FRAME_BITS-1];
  assign mdio_oe = busy_q && (!rd_q || bit_q < BIT_W'(TA_IDX));

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      4'h0: begin
        reg_rdata[DIV_W-1:0] = div_q;
        reg_rdata[EN_BIT]    = en_q;
      end
      4'h4: reg_rdata[12]   = !busy_q;
      4'h8: reg_rdata[15:0] = wdat_q;
      4'hC: reg_rdata[15:0] = rdat_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mgmt_phy_master_chk.sv
module mgmt_phy_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        en_q,
  input logic        busy_q,
  input logic        rd_q,
  input logic        reg_we,
  input logic [3:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata
);
  p_idle_mdc_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdc);

  p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!mdc && !mdio_oe && !busy_q));

  p_launch_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'h4 && reg_wdata[11] && en_q && !busy_q) |=> busy_q);

  p_busy_keeps_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(rd_q));

  p_mdio_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  p_read_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 4'hC) |-> (reg_rdata[31:16] == 16'h0));
endmodule

bind mgmt_phy_master mgmt_phy_master_chk i_chk (.*);

// File: tb/test_mgmt_phy_master.sv
module test_mgmt_phy_master;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, mdio_i = 1'b1;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_o, mdio_oe;

  mgmt_phy_master i_mgmt_phy_master (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // PHY model
  int pc = 0, oe_cnt = 0;
  logic [63:0] cap = '0;
  logic [15:0] reply = '0;
  always @(posedge mdc) begin
    cap = {cap[62:0], mdio_oe ? mdio_o : 1'b0};
    if (mdio_oe) oe_cnt++;
    pc++;
  end
  always @(negedge mdc) if (pc >= 48 && pc <= 63) mdio_i = reply[15-(pc-48)];

  // MDC period monitor
  int cyc = 0, last_rise = 0, rise_n = 0, pmin = 0, pmax = 0;
  logic mdc_prev = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (mdc && !mdc_prev) begin
      if (rise_n > 0) begin
        if (pmin == 0 || cyc - last_rise < pmin) pmin = cyc - last_rise;
        if (cyc - last_rise > pmax) pmax = cyc - last_rise;
      end
      rise_n++;
      last_rise = cyc;
    end
    mdc_prev = mdc;
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_ready();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(4'h4, v);
      if (v[12]) return;
    end
    check(1'b0, "R7 ready timeout", 0, 1);
  endtask

  task automatic arm(input logic [15:0] data);
    reply = data; pc = 0; cap = '0; oe_cnt = 0; mdio_i = 1'b1;
    rise_n = 0; pmin = 0; pmax = 0;
  endtask

  localparam logic [34:0] VEC [5] = '{
    {8'd0, 1'b0, 5'h01, 5'h00, 16'hA5C3},
    {8'd1, 1'b1, 5'h1F, 5'h11, 16'h8001},
    {8'd2, 1'b0, 5'h12, 5'h1E, 16'h5A3C},
    {8'd3, 1'b1, 5'h05, 5'h0A, 16'hFFFF},
    {8'd4, 1'b0, 5'h10, 5'h03, 16'h0F0F}
  };

  initial begin
    #(8*150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'h0, v); check(v == 0, "R1 ctrl", v, 0);
    rd(4'h4, v); check(v == 32'h1000, "R1 cmd", v, 32'h1000);
    rd(4'h8, v); check(v == 0, "R1 wdata", v, 0);
    rd(4'hC, v); check(v == 0, "R1 rdata", v, 0);
    check(!mdc && !mdio_oe, "R1 pins", {mdc, mdio_oe}, 0);

    // R10 register map readback
    wr(4'h8, 32'hDEAD_1234); rd(4'h8, v); check(v == 32'h1234, "R10 wdata", v, 32'h1234);
    wr(4'h0, 32'h0000_0007); rd(4'h0, v); check(v == 32'h7, "R10 ctrl", v, 32'h7);

    // R3 disabled: initiate ignored, no MDC
    arm(16'h0);
    wr(4'h4, 32'h0000_0800);
    repeat (100) @(negedge clk);
    rd(4'h4, v); check(v[12], "R3 ready stays", v, 32'h1000);
    check(rise_n == 0, "R3 no mdc", rise_n, 0);

    // Table of frames: R2 R4 R5 R6 R7
    foreach (VEC[k]) begin
      logic [7:0] dv; logic isrd; logic [4:0] ph, rg; logic [15:0] dt;
      {dv, isrd, ph, rg, dt} = VEC[k];
      wr(4'h0, 32'h0001_0000 | 32'(dv));
      if (!isrd) wr(4'h8, 32'(dt));
      arm(dt);
      wr(4'h4, 32'(isrd) << 10 | 32'h800 | 32'(rg) << 5 | 32'(ph));
      rd(4'h4, v); check(!v[12], "R7 busy after launch", v, 0);
      wait_ready();
      exp = {32'hFFFF_FFFF, 2'b01, isrd ? 2'b10 : 2'b01, ph, rg, 2'b10, dt};
      check(pc == 64, "R4 bit count", pc, 64);
      check(cap[63:18] == exp[63:18], "R4 header", cap, exp);
      check(pmin == 2*(dv+1) && pmax == 2*(dv+1), "R2 mdc period", {pmin, pmax}, 2*(dv+1));
      check(!mdc, "R2 idle low", mdc, 0);
      if (isrd) begin
        check(oe_cnt == 46, "R6 driven bits", oe_cnt, 46);
        rd(4'hC, v); check(v == 32'(dt), "R6 read data", v, 32'(dt));
      end else begin
        check(oe_cnt == 64, "R5 driven bits", oe_cnt, 64);
        check(cap[17:0] == exp[17:0], "R5 ta+data", cap[17:0], exp[17:0]);
      end
    end

    // R8 initiate while busy ignored
    wr(4'h0, 32'h0001_0001);
    wr(4'h8, 32'h0000_C33C);
    arm(16'h0);
    wr(4'h4, 32'h0000_0800 | 32'h3 << 5 | 32'h7);
    repeat (40) @(negedge clk);
    wr(4'h4, 32'h0000_0C00 | 32'h1F << 5 | 32'h1F);
    wait_ready();
    exp = {32'hFFFF_FFFF, 4'b0101, 5'h07, 5'h03, 2'b10, 16'hC33C};
    check(cap == exp && oe_cnt == 64, "R8 frame unchanged", cap, exp);
    rd(4'hC, v); check(v == 32'hFFFF, "R8 rdata untouched", v, 32'hFFFF);

    // R11 abort by clearing enable
    arm(16'h0);
    wr(4'h4, 32'h0000_0800);
    repeat (30) @(negedge clk);
    wr(4'h0, 32'h0000_0001);
    rd(4'h4, v); check(v[12], "R11 ready after abort", v, 32'h1000);
    rise_n = 0;
    repeat (50) @(negedge clk);
    check(!mdc && !mdio_oe && rise_n == 0, "R11 bus quiet", {mdc, mdio_oe, rise_n}, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule